// File: doc/BRIEF.md
# Multichannel PWM Controller with Register Port

This block holds four independent pulse-width modulation channels behind a flat, word-addressed register port. A group of global registers starts and stops channels, masks and unmasks their interrupts, and collects one pending flag per channel. Each channel has its own window of four registers: a mode word, a duty threshold, a period length and a read-only view of its counter.

Each running channel advances its counter on a chosen count source. The source is either every clock cycle or one of two external tick strobes, which come from a clock generator outside the block. The counter either ramps up and wraps, or ramps up and back down, which makes the period twice as long. The channel output is active while the counter sits below the duty threshold. The channel raises its pending flag each time the counter returns to zero. Software reads the pending register to learn which channels finished a period, and the read clears what it returned. A single interrupt line is raised while any unmasked flag is pending.

The register port carries no stream. Every access is accepted in the cycle it is presented, so there is no ready signal and no back-pressure. Read data comes back one cycle later, marked by a valid strobe.

Top module: `pwm_multi_ctrl`

## Requirements
- R1: After reset, every register reads zero, every output is low, the interrupt line is low and no read data is marked valid.
- R2: Writing word 0x04 starts each channel whose bit is 1, and writing word 0x08 stops each channel whose bit is 1. Bits written as 0 leave their channel unchanged. Word 0x0C reads back the set of running channels, with channel n at bit n.
- R3: Writing word 0x10 sets the mask bits written as 1, and writing word 0x14 clears them. Word 0x18 reads the resulting mask. Zero bits have no effect.
- R4: The register window of channel n starts at 0x200 + n×0x20. Inside it, the mode word is at +0x0, the duty at +0x4, the period at +0x8 and the read-only counter at +0xC. In the mode word, bits [1:0] choose the count source (0 every cycle, 1 tick A, 2 tick B, 3 halted), bit 8 selects up-down counting and bit 9 inverts the output. A channel ignores the strobes of any source it has not chosen.
- R5: In ramp mode with period P ≥ 1, a running counter goes 0, 1, … P−1 and then back to 0, one step per source event. The step that returns it to 0 sets the channel's pending bit.
- R6: In up-down mode with period P ≥ 1, a running counter goes up from 0 to P and then down to 0. A full period is 2P steps, and the step that lands on 0 sets the pending bit.
- R7: While a channel is running, its output is active when the counter is below the duty value. Active is high, or low when inverted. A stopped channel holds its counter at 0 and drives the inactive level.
- R8: A running channel with a period of 0 does not count and never sets its pending bit.
- R9: Reading word 0x1C returns the pending bits and clears the bits it returned. A flag raised on the same clock edge as that read stays pending.
- R10: The interrupt line is high exactly when some pending bit has its mask bit set.
- R11: Read data and its valid strobe appear one cycle after the read strobe. Addresses outside the map, and the write-only words, read as 0. Writes to addresses outside the map and to the counter words change nothing.
- R12: Word 0x00 is a read/write configuration word for the external clock generator and drives the `clkgen_cfg` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for bus_addr / bus_wdata |
| bus_rd | input | 1 | Read strobe for bus_addr |
| bus_addr | input | 10 | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | High in the cycle bus_rdata holds a read result |
| tick_a | input | 1 | Count strobe from clock generator output A |
| tick_b | input | 1 | Count strobe from clock generator output B |
| clkgen_cfg | output | 32 | Configuration word held for the clock generator |
| pwm_out | output | 4 | Channel waveforms, bit n for channel n |
| irq | output | 1 | Interrupt request |

## Verification
The acknowledge from a read of the pending word and a new end-of-period flag can fall on the same clock edge. The bench provokes this by running a channel with a short ramp period and placing a pending read exactly on the edge where the counter wraps. The first read must return the older flag. The read that follows must still see the new flag, and the read after that must see nothing. Every other pending test is judged against edges counted from the cycle that enables the channel.

// File: rtl/pwm_ctl_pkg.sv
`timescale 1ns/1ps
package pwm_ctl_pkg;

  // Global word index = byte address [4:2]
  typedef enum logic [2:0] {
    G_CFG  = 3'd0,
    G_RUN  = 3'd1,
    G_STOP = 3'd2,
    G_STAT = 3'd3,
    G_MSET = 3'd4,
    G_MCLR = 3'd5,
    G_MASK = 3'd6,
    G_PEND = 3'd7
  } glb_e;

  // Per-channel word index = window offset [3:2]
  typedef enum logic [1:0] {
    C_MODE   = 2'd0,
    C_DUTY   = 2'd1,
    C_PERIOD = 2'd2,
    C_COUNT  = 2'd3
  } chreg_e;

  typedef enum logic [1:0] {
    SRC_MCLK  = 2'd0,
    SRC_TICKA = 2'd1,
    SRC_TICKB = 2'd2,
    SRC_HALT  = 2'd3
  } src_e;

  typedef struct packed {
    logic invert;
    logic center;
    src_e src;
  } chmode_t;

  localparam int unsigned MODE_CENTER_BIT = 8;
  localparam int unsigned MODE_INVERT_BIT = 9;
  localparam int unsigned GLB_WORDS       = 8;

endpackage

// File: rtl/pwm_addr_map.sv
`timescale 1ns/1ps
module pwm_addr_map
  import pwm_ctl_pkg::*;
#(
  parameter int unsigned AW        = 10,
  parameter int unsigned NCH       = 4,
  parameter int unsigned CH_BASE   = 512,
  parameter int unsigned STRIDE_LG = 5
) (
  input  logic [AW-1:0]  addr,
  output logic           glb_hit,
  output glb_e           glb_sel,
  output logic [NCH-1:0] ch_hit,
  output chreg_e         ch_sel
);
  localparam int unsigned GLB_SPAN = GLB_WORDS * 4;
  localparam int unsigned IDX_W    = AW - STRIDE_LG;

  logic [AW-1:0] ch_off;
  logic          in_window;

  always_comb begin
    glb_hit   = (addr < AW'(GLB_SPAN)) && (addr[1:0] == 2'b00);
    glb_sel   = glb_e'(addr[4:2]);
    ch_off    = addr - AW'(CH_BASE);
    ch_sel    = chreg_e'(ch_off[3:2]);
    in_window = (addr >= AW'(CH_BASE)) && (ch_off[1:0] == 2'b00)
                && (ch_off[STRIDE_LG-1:4] == '0);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign ch_hit[i] = in_window && (ch_off[AW-1:STRIDE_LG] == IDX_W'(i));
  end

endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan
  import pwm_ctl_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr,
  input  chreg_e        wsel,
  input  logic [DW-1:0] wdata,
  input  chreg_e        rsel,
  input  logic          tick_a,
  input  logic          tick_b,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] cnt_o,
  output logic          wave,
  output logic          wrap
);
  chmode_t       mode_q;
  logic [CW-1:0] duty_q, prd_q, cnt_q;
  logic          down_q;

  logic          src_tick, adv, falling, wrap_c, down_nx;
  logic [CW:0]   inc;
  logic [CW-1:0] cnt_nx;
  logic          unused_bits;

  assign unused_bits = ^wdata;

  always_comb begin
    unique case (mode_q.src)
      SRC_MCLK:  src_tick = 1'b1;
      SRC_TICKA: src_tick = tick_a;
      SRC_TICKB: src_tick = tick_b;
      default:   src_tick = 1'b0;
    endcase
    adv     = run && (prd_q != '0) && src_tick;
    inc     = {1'b0, cnt_q} + 1'b1;
    falling = 1'b0;
    if (!mode_q.center) begin
      // ramp: wrap once the next value reaches the period
      cnt_nx  = (inc >= {1'b0, prd_q}) ? '0 : inc[CW-1:0];
      down_nx = 1'b0;
      wrap_c  = (cnt_nx == '0);
    end else begin
      // up-down: turn at the period, flag on landing at zero
      falling = (down_q || (cnt_q >= prd_q)) && (cnt_q != '0);
      cnt_nx  = falling ? (cnt_q - 1'b1) : inc[CW-1:0];
      down_nx = falling && (cnt_nx != '0);
      wrap_c  = falling && (cnt_nx == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      duty_q <= '0;
      prd_q  <= '0;
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      if (wr) begin
        unique case (wsel)
          C_MODE: begin
            mode_q.src    <= src_e'(wdata[1:0]);
            mode_q.center <= wdata[MODE_CENTER_BIT];
            mode_q.invert <= wdata[MODE_INVERT_BIT];
          end
          C_DUTY:   duty_q <= wdata[CW-1:0];
          C_PERIOD: prd_q  <= wdata[CW-1:0];
          default: ;
        endcase
      end
      if (!run) begin
        cnt_q  <= '0;
        down_q <= 1'b0;
      end else if (adv) begin
        cnt_q  <= cnt_nx;
        down_q <= down_nx;
      end
    end
  end

  assign wrap  = adv && wrap_c;
  assign wave  = (run && (cnt_q < duty_q)) ^ mode_q.invert;
  assign cnt_o = cnt_q;

  always_comb begin
    rdata = '0;
    unique case (rsel)
      C_MODE: begin
        rdata[1:0]             = mode_q.src;
        rdata[MODE_CENTER_BIT] = mode_q.center;
        rdata[MODE_INVERT_BIT] = mode_q.invert;
      end
      C_DUTY:   rdata = DW'(duty_q);
      C_PERIOD: rdata = DW'(prd_q);
      default:  rdata = DW'(cnt_q);
    endcase
  end

endmodule

// File: rtl/pwm_glb_regs.sv
`timescale 1ns/1ps
module pwm_glb_regs
  import pwm_ctl_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_stb,
  input  logic           rd_stb,
  input  glb_e           sel,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] wrap,
  output logic [NCH-1:0] run,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] pend,
  output logic [DW-1:0]  cfg,
  output logic [DW-1:0]  rdata,
  output logic           irq
);
  logic [NCH-1:0] run_q, mask_q, pend_q;
  logic [DW-1:0]  cfg_q;
  logic [NCH-1:0] bits;
  logic           ack;

  assign bits = wdata[NCH-1:0];
  assign ack  = rd_stb && (sel == G_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_stb) begin
        unique case (sel)
          G_CFG:  cfg_q  <= wdata;
          G_RUN:  run_q  <= run_q | bits;
          G_STOP: run_q  <= run_q & ~bits;
          G_MSET: mask_q <= mask_q | bits;
          G_MCLR: mask_q <= mask_q & ~bits;
          default: ;
        endcase
      end
      // a fresh flag wins over the acknowledge of the same edge
      pend_q <= (ack ? '0 : pend_q) | wrap;
    end
  end

  always_comb begin
    unique case (sel)
      G_CFG:   rdata = cfg_q;
      G_STAT:  rdata = DW'(run_q);
      G_MASK:  rdata = DW'(mask_q);
      G_PEND:  rdata = DW'(pend_q);
      default: rdata = '0;
    endcase
  end

  assign run  = run_q;
  assign mask = mask_q;
  assign pend = pend_q;
  assign cfg  = cfg_q;
  assign irq  = |(pend_q & mask_q);

endmodule

// File: rtl/pwm_multi_ctrl.sv
`timescale 1ns/1ps
module pwm_multi_ctrl
  import pwm_ctl_pkg::*;
#(
  parameter int unsigned NCH       = 4,
  parameter int unsigned CW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned AW        = 10,
  parameter int unsigned CH_BASE   = 512,
  parameter int unsigned STRIDE_LG = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_rvalid,
  input  logic           tick_a,
  input  logic           tick_b,
  output logic [DW-1:0]  clkgen_cfg,
  output logic [NCH-1:0] pwm_out,
  output logic           irq
);
  logic                    glb_hit;
  glb_e                    glb_sel;
  logic [NCH-1:0]          ch_hit;
  chreg_e                  ch_sel;
  logic [NCH-1:0]          run_w, mask_w, pend_w, wrap_w;
  logic [DW-1:0]           glb_rdata;
  logic [DW-1:0]           ch_rdata [NCH];
  logic [NCH-1:0][CW-1:0]  cnt_v;
  logic [DW-1:0]           rd_mux, rdata_q;
  logic                    rvalid_q;

  pwm_addr_map #(
    .AW(AW), .NCH(NCH), .CH_BASE(CH_BASE), .STRIDE_LG(STRIDE_LG)
  ) u_map (
    .addr    (bus_addr),
    .glb_hit (glb_hit),
    .glb_sel (glb_sel),
    .ch_hit  (ch_hit),
    .ch_sel  (ch_sel)
  );

  pwm_glb_regs #(.NCH(NCH), .DW(DW)) u_glb (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (bus_wr && glb_hit),
    .rd_stb (bus_rd && glb_hit),
    .sel    (glb_sel),
    .wdata  (bus_wdata),
    .wrap   (wrap_w),
    .run    (run_w),
    .mask   (mask_w),
    .pend   (pend_w),
    .cfg    (clkgen_cfg),
    .rdata  (glb_rdata),
    .irq    (irq)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pwm_chan #(.CW(CW), .DW(DW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_w[i]),
      .wr     (bus_wr && ch_hit[i]),
      .wsel   (ch_sel),
      .wdata  (bus_wdata),
      .rsel   (ch_sel),
      .tick_a (tick_a),
      .tick_b (tick_b),
      .rdata  (ch_rdata[i]),
      .cnt_o  (cnt_v[i]),
      .wave   (pwm_out[i]),
      .wrap   (wrap_w[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (glb_hit) rd_mux = glb_rdata;
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) rd_mux = ch_rdata[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= bus_rd ? rd_mux : '0;
      rvalid_q <= bus_rd;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

endmodule

// File: rtl/pwm_multi_ctrl_chk.sv
`timescale 1ns/1ps
module pwm_multi_ctrl_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_wr,
  input logic                   bus_rd,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_rvalid,
  input logic                   irq,
  input logic [NCH-1:0]         run_q,
  input logic [NCH-1:0]         mask_q,
  input logic [NCH-1:0]         pend_q,
  input logic [NCH-1:0]         wrap_v,
  input logic [NCH-1:0][CW-1:0] cnt_v
);
  localparam logic [AW-1:0] PEND_ADDR = AW'(28);

  a_r11_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  a_r11_rvalid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  a_r2_run_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(run_q));
  a_r3_mask_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(mask_q));
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
  a_r10_pend_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q == '0) |-> !irq);
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr == PEND_ADDR) && (wrap_v == '0)) |=> (pend_q == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_lane
    a_r7_idle_counter: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q[i] |=> (cnt_v[i] == '0));
    a_r9_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap_v[i] && !pend_q[i]) |=> !pend_q[i]);
    a_r5_wrap_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_v[i] |-> run_q[i]);
  end

endmodule

bind pwm_multi_ctrl pwm_multi_ctrl_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_rvalid (bus_rvalid),
  .irq        (irq),
  .run_q      (run_w),
  .mask_q     (mask_w),
  .pend_q     (pend_w),
  .wrap_v     (wrap_w),
  .cnt_v      (cnt_v)
);

// File: tb/pwm_multi_ctrl_test.sv
`timescale 1ns/1ps
module pwm_multi_ctrl_test;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int DW  = 32;
  localparam int AW  = 10;
  localparam int NV  = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [DW-1:0]  bus_wdata = '0;
  logic [DW-1:0]  bus_rdata;
  logic           bus_rvalid;
  logic           tick_a = 1'b0, tick_b = 1'b0;
  logic [DW-1:0]  clkgen_cfg;
  logic [NCH-1:0] pwm_out;
  logic           irq;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  pwm_multi_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .tick_a(tick_a), .tick_b(tick_b),
    .clkgen_cfg(clkgen_cfg), .pwm_out(pwm_out), .irq(irq)
  );

  // {req, write addr, write data, read addr, expected}
  localparam logic [103:0] VEC [NV] = '{
    {8'd12, 16'h000, 32'hA5A51234, 16'h000, 32'hA5A51234}, // R12 config word
    {8'd3,  16'h010, 32'h00000005, 16'h018, 32'h00000005}, // R3 set mask
    {8'd3,  16'h010, 32'h00000002, 16'h018, 32'h00000007}, // R3 set adds
    {8'd3,  16'h014, 32'h00000004, 16'h018, 32'h00000003}, // R3 clear
    {8'd3,  16'h014, 32'h00000000, 16'h018, 32'h00000003}, // R3 zero bits
    {8'd2,  16'h004, 32'h00000009, 16'h00C, 32'h00000009}, // R2 start
    {8'd2,  16'h008, 32'h00000001, 16'h00C, 32'h00000008}, // R2 stop
    {8'd2,  16'h004, 32'h00000000, 16'h00C, 32'h00000008}, // R2 zero bits
    {8'd2,  16'h008, 32'h00000008, 16'h00C, 32'h00000000}, // R2 stop last
    {8'd4,  16'h204, 32'h00001234, 16'h204, 32'h00001234}, // R4 ch0 duty
    {8'd4,  16'h228, 32'h0000BEEF, 16'h228, 32'h0000BEEF}, // R4 ch1 period
    {8'd4,  16'h260, 32'hFFFFFFFF, 16'h260, 32'h00000303}, // R4 ch3 mode fields
    {8'd11, 16'h290, 32'h00000055, 16'h290, 32'h00000000}, // R11 past last channel
    {8'd11, 16'h210, 32'h00000077, 16'h300, 32'h00000000}, // R11 window hole
    {8'd11, 16'h020, 32'h00000001, 16'h004, 32'h00000000}, // R11 write-only word
    {8'd11, 16'h26C, 32'h00000099, 16'h26C, 32'h00000000}  // R11 counter read-only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_a();
    tick_a = 1'b1; @(negedge clk); tick_a = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_b();
    tick_b = 1'b1; @(negedge clk); tick_b = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (R1..all): got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] got, g2, g3;
    int sv [6] = '{0, 1, 2, 3, 2, 1};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pwm_out", 32'(pwm_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 clkgen_cfg", clkgen_cfg, 32'h0);
    check("R1 rvalid", 32'(bus_rvalid), 32'h0);
    rd(12'h00C, got); check("R1 status", got, 32'h0);
    check("R11 rvalid after read", 32'(bus_rvalid), 32'h1);
    rd(12'h018, got); check("R1 mask", got, 32'h0);
    rd(12'h01C, got); check("R1 pending", got, 32'h0);
    rd(12'h208, got); check("R1 ch0 period", got, 32'h0);
    @(negedge clk);
    check("R11 rvalid idle", 32'(bus_rvalid), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(int'(VEC[i][95:80]), VEC[i][79:48]);
      rd(int'(VEC[i][47:32]), got);
      check($sformatf("R%0d vector %0d", VEC[i][103:96], i), got, VEC[i][31:0]);
    end
    check("R12 clkgen_cfg port", clkgen_cfg, 32'hA5A51234);

    wr(12'h014, 32'hF);
    wr(12'h008, 32'hF);
    rd(12'h01C, got);

    // R5 / R7 ramp channel 0, period 4, duty 2
    wr(12'h200, 32'h0); wr(12'h204, 32'h2); wr(12'h208, 32'h4);
    wr(12'h004, 32'h1);
    for (int k = 0; k <= 8; k++) begin
      if (k > 0) @(negedge clk);
      check($sformatf("R7 ramp wave step %0d", k), 32'(pwm_out[0]), 32'((k % 4) < 2));
      if (k == 4) check("R10 masked flag keeps irq low", 32'(irq), 32'h0);
    end
    wr(12'h008, 32'h1);
    check("R7 stopped output inactive", 32'(pwm_out[0]), 32'h0);
    @(negedge clk);
    rd(12'h20C, got); check("R7 stopped counter held", got, 32'h0);
    rd(12'h01C, got); check("R5 ramp wrap flag", got, 32'h1);
    rd(12'h01C, got); check("R9 read clears", got, 32'h0);

    // R10 interrupt line
    wr(12'h010, 32'h1);
    wr(12'h004, 32'h1);
    repeat (3) @(negedge clk);
    check("R10 irq before wrap", 32'(irq), 32'h0);
    @(negedge clk);
    check("R10 irq after wrap", 32'(irq), 32'h1);
    rd(12'h01C, got); check("R9 pending on irq", got, 32'h1);
    check("R10 irq dropped after ack", 32'(irq), 32'h0);
    wr(12'h008, 32'h1);
    wr(12'h014, 32'h1);

    // R9 acknowledge and wrap on the same edge
    rd(12'h01C, got);
    wr(12'h004, 32'h1);
    repeat (7) @(negedge clk);
    rd(12'h01C, got);
    rd(12'h01C, g2);
    rd(12'h01C, g3);
    check("R9 read on wrap edge", got, 32'h1);
    check("R9 same-edge flag kept", g2, 32'h1);
    check("R9 then empty", g3, 32'h0);
    wr(12'h008, 32'h1);

    // R6 up-down channel 1, period 3, duty 2
    wr(12'h220, 32'h100); wr(12'h224, 32'h2); wr(12'h228, 32'h3);
    rd(12'h01C, got);
    wr(12'h004, 32'h2);
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      check($sformatf("R6 up-down wave step %0d", k), 32'(pwm_out[1]), 32'(sv[k % 6] < 2));
    end
    rd(12'h22C, got); check("R6 counter on way down", got, 32'h1);
    wr(12'h008, 32'h2);
    rd(12'h01C, got); check("R6 flag at zero", got, 32'h2);

    // R7 inversion, R8 zero period, channel 2
    wr(12'h240, 32'h200);
    check("R7 inverted idle level", 32'(pwm_out[2]), 32'h1);
    wr(12'h248, 32'h0); wr(12'h244, 32'h1);
    rd(12'h01C, got);
    wr(12'h004, 32'h4);
    repeat (5) @(negedge clk);
    check("R7 inverted active level", 32'(pwm_out[2]), 32'h0);
    rd(12'h24C, got); check("R8 zero period holds counter", got, 32'h0);
    rd(12'h01C, got); check("R8 zero period no flag", got, 32'h0);
    wr(12'h008, 32'h4);
    check("R7 inverted after stop", 32'(pwm_out[2]), 32'h1);

    // R4 count sources, channel 3, period 2
    wr(12'h260, 32'h1); wr(12'h264, 32'h1); wr(12'h268, 32'h2);
    rd(12'h01C, got);
    wr(12'h004, 32'h8);
    repeat (3) pulse_b();
    rd(12'h26C, got); check("R4 tick B ignored on source A", got, 32'h0);
    repeat (3) pulse_a();
    rd(12'h26C, got); check("R5 tick A counting", got, 32'h1);
    rd(12'h01C, got); check("R5 tick A wrap flag", got, 32'h8);
    wr(12'h260, 32'h3);
    repeat (2) pulse_a();
    rd(12'h26C, got); check("R4 halted source", got, 32'h1);
    wr(12'h260, 32'h2);
    pulse_b();
    rd(12'h26C, got); check("R4 tick B source", got, 32'h0);
    rd(12'h01C, got); check("R4 tick B wrap flag", got, 32'h8);
    wr(12'h008, 32'h8);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule